// File: doc/BRIEF.md
# USB Port Routing Claim Controller

This block owns a 32-bit routing word that steers shared USB ports to one of two controllers each. Several requesters can ask for a port at once. A requester names a port and the index of the target it wants. The first claim on an idle port wins. It becomes the owner, and the block rewrites only that port's select field in the routing word. Any later claim on the same port is refused as busy until some requester releases the port.

Every request lane gets a one-cycle response strobe in the cycle after its request. The strobe carries exactly one of three results: ok, busy or error. The routing word is always visible on an output, together with each port's ownership flag and the target index it recorded. Port 1 can be owned, but it has no routing field, so claiming it leaves the word alone.

Top module: `usb_route_claim`

## Requirements
- R1: After reset the routing word is all zeros, every port is idle and no response strobe is raised.
- R2: A valid claim on an idle port marks the port owned and records the claimed target index. In the next cycle the lane shows a one-cycle ok strobe, and the word, owned flag and recorded target show the new state.
- R3: Port 0 uses bits [5:4] of the routing word. Target 0 writes 2'b01, which routes the port to the PCI EHCI/OHCI host. Target 1 writes 2'b11, which routes it to the high-speed USB controller. The value 2'b10 never appears.
- R4: Port 2 uses bit 31. Target 0 writes 0, which routes the port to the PCI EHCI/OHCI host. Target 1 writes 1, which routes it to the xHCI controller.
- R5: A granted claim clears only its own port's field and then sets the target's value. All other bits keep their value, and bits outside both fields stay zero. A claim on port 1 is granted and leaves the word unchanged.
- R6: A claim on an owned port responds busy. The word, the owned flag and the recorded target stay unchanged.
- R7: A release (request with the release bit set) on ports 0 to 2 responds ok and makes the port idle. The routing field keeps its last value.
- R8: A request with a port number above 2, or a claim with a target index of 2 or more, responds error and changes no state.
- R9: When several lanes claim the same idle port in one cycle, only the lowest-numbered lane is granted and the others respond busy. Claims on different idle ports in the same cycle are all granted.
- R10: A response strobe lasts one cycle and carries exactly one of ok, busy or error. A lane without a request in the previous cycle shows no strobe.
- R11: In one cycle, a claim on an owned port combined with a release of that port responds busy, and the port ends idle. A claim on an idle port combined with a release of that port is granted, and the port ends owned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | NUM_REQ | Request valid, one bit per lane |
| req_release_i | input | NUM_REQ | 1 = release, 0 = claim, per lane |
| req_port_i | input | NUM_REQ*2 | Port number per lane (lane l at bits [2l+1:2l]) |
| req_target_i | input | NUM_REQ*2 | Target index per lane (lane l at bits [2l+1:2l]) |
| rsp_valid_o | output | NUM_REQ | Response strobe per lane |
| rsp_ok_o | output | NUM_REQ | Claim granted or release accepted |
| rsp_busy_o | output | NUM_REQ | Claim refused because the port is owned |
| rsp_err_o | output | NUM_REQ | Bad port number or target index |
| route_word_o | output | 32 | Routing word |
| port_owned_o | output | 3 | Ownership flag per port |
| port_target_o | output | 3 | Recorded target index per port |

## Verification
The bench aims at same-cycle collisions between lanes. If the design granted two claims on one port, two lanes would see ok, and the second lane's field value would replace the first owner's. The bench also pairs a claim with a release in one cycle: a design that applied the release first would grant a claim that should be refused as busy. Other targets are a claim on port 1, where a wrong mask would corrupt port 0's field or bit 31, and error requests, where a design that let an invalid request through would change the word or the ownership. Random traffic then checks that neither routing field is disturbed by claims on the other port.

// File: rtl/usb_route_pkg.sv
package usb_route_pkg;
  localparam int NUM_PORTS = 3;
  localparam int PORT_W    = 2;
  localparam int TGT_W     = 2;
  localparam int NUM_TGT   = 2;
  localparam int WORD_W    = 32;

  typedef enum logic [1:0] {RSP_NONE, RSP_OK, RSP_BUSY, RSP_ERR} rsp_e;

  function automatic logic [WORD_W-1:0] field_mask(input int p);
    logic [WORD_W-1:0] m;
    m = '0;
    case (p)
      0: m[5:4] = 2'b11;
      2: m[31]  = 1'b1;
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] field_value(input int p, input logic tgt);
    logic [WORD_W-1:0] v;
    v = '0;
    case (p)
      0: v[5:4] = tgt ? 2'b11 : 2'b01;
      2: v[31]  = tgt;
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic logic [WORD_W-1:0] all_masks();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int p = 0; p < NUM_PORTS; p++) m |= field_mask(p);
    return m;
  endfunction
endpackage

// File: rtl/usb_route_arb.sv
module usb_route_arb
  import usb_route_pkg::*;
#(
  parameter int NUM_REQ = 2
) (
  input  logic [NUM_REQ-1:0]        valid_i,
  input  logic [NUM_REQ-1:0]        release_i,
  input  logic [NUM_REQ*PORT_W-1:0] port_i,
  input  logic [NUM_REQ*TGT_W-1:0]  target_i,
  input  logic [NUM_PORTS-1:0]      owned_i,
  output rsp_e                      code_o [NUM_REQ],
  output logic [NUM_PORTS-1:0]      grant_o,
  output logic [NUM_PORTS-1:0]      grant_tgt_o,
  output logic [NUM_PORTS-1:0]      release_o
);
  logic [NUM_PORTS-1:0] taken;

  // lanes are served in index order; a port taken earlier in the loop is busy
  always_comb begin
    taken       = owned_i;
    grant_o     = '0;
    grant_tgt_o = '0;
    release_o   = '0;
    for (int l = 0; l < NUM_REQ; l++) begin
      logic [PORT_W-1:0] pt;
      logic [TGT_W-1:0]  tg;
      logic              port_ok;
      pt      = port_i[l*PORT_W +: PORT_W];
      tg      = target_i[l*TGT_W +: TGT_W];
      port_ok = 32'(pt) < NUM_PORTS;
      code_o[l] = RSP_NONE;
      if (valid_i[l]) begin
        if (!port_ok) begin
          code_o[l] = RSP_ERR;
        end else if (release_i[l]) begin
          code_o[l] = RSP_OK;
          for (int p = 0; p < NUM_PORTS; p++)
            if (32'(pt) == p) release_o[p] = 1'b1;
        end else if (32'(tg) >= NUM_TGT) begin
          code_o[l] = RSP_ERR;
        end else begin
          for (int p = 0; p < NUM_PORTS; p++) begin
            if (32'(pt) == p) begin
              if (taken[p]) begin
                code_o[l] = RSP_BUSY;
              end else begin
                code_o[l]      = RSP_OK;
                taken[p]       = 1'b1;
                grant_o[p]     = 1'b1;
                grant_tgt_o[p] = tg[0];
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/usb_route_owner.sv
module usb_route_owner
  import usb_route_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PORTS-1:0] grant_i,
  input  logic [NUM_PORTS-1:0] grant_tgt_i,
  input  logic [NUM_PORTS-1:0] release_i,
  output logic [NUM_PORTS-1:0] owned_o,
  output logic [NUM_PORTS-1:0] tgt_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        owned_o[p] <= 1'b0;
        tgt_o[p]   <= 1'b0;
      end else if (grant_i[p]) begin
        owned_o[p] <= 1'b1;
        tgt_o[p]   <= grant_tgt_i[p];
      end else if (release_i[p]) begin
        owned_o[p] <= 1'b0;
      end
    end

    p_no_double_grant_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_i[p] |-> !owned_o[p]);
    p_release_idles_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (release_i[p] && !grant_i[p]) |=> !owned_o[p]);
    p_busy_keeps_tgt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (owned_o[p] && !release_i[p]) |=> (owned_o[p] && $stable(tgt_o[p])));
  end
endmodule

// File: rtl/usb_route_reg.sv
module usb_route_reg
  import usb_route_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PORTS-1:0] grant_i,
  input  logic [NUM_PORTS-1:0] grant_tgt_i,
  output logic [WORD_W-1:0]    word_o
);
  logic [WORD_W-1:0] word_d;

  // masked read-modify-write per granted port
  always_comb begin
    word_d = word_o;
    for (int p = 0; p < NUM_PORTS; p++)
      if (grant_i[p])
        word_d = (word_d & ~field_mask(p)) | field_value(p, grant_tgt_i[p]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_o <= '0;
    else         word_o <= word_d;
  end

  p_no_grant_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i == '0) |=> $stable(word_o));
  p_outside_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_o & ~all_masks()) == '0);
  p_port0_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_o[5:4] != 2'b10);
  p_port2_follow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i[2] |=> (word_o[31] == $past(grant_tgt_i[2])));
endmodule

// File: rtl/usb_route_claim.sv
module usb_route_claim
  import usb_route_pkg::*;
#(
  parameter int NUM_REQ = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_REQ-1:0]          req_valid_i,
  input  logic [NUM_REQ-1:0]          req_release_i,
  input  logic [NUM_REQ*PORT_W-1:0]   req_port_i,
  input  logic [NUM_REQ*TGT_W-1:0]    req_target_i,
  output logic [NUM_REQ-1:0]          rsp_valid_o,
  output logic [NUM_REQ-1:0]          rsp_ok_o,
  output logic [NUM_REQ-1:0]          rsp_busy_o,
  output logic [NUM_REQ-1:0]          rsp_err_o,
  output logic [WORD_W-1:0]           route_word_o,
  output logic [NUM_PORTS-1:0]        port_owned_o,
  output logic [NUM_PORTS-1:0]        port_target_o
);
  rsp_e                 code [NUM_REQ];
  logic [NUM_PORTS-1:0] grant, grant_tgt, rel;

  usb_route_arb #(.NUM_REQ(NUM_REQ)) u_arb (
    .valid_i    (req_valid_i),
    .release_i  (req_release_i),
    .port_i     (req_port_i),
    .target_i   (req_target_i),
    .owned_i    (port_owned_o),
    .code_o     (code),
    .grant_o    (grant),
    .grant_tgt_o(grant_tgt),
    .release_o  (rel)
  );

  usb_route_owner u_owner (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .grant_i    (grant),
    .grant_tgt_i(grant_tgt),
    .release_i  (rel),
    .owned_o    (port_owned_o),
    .tgt_o      (port_target_o)
  );

  usb_route_reg u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .grant_i    (grant),
    .grant_tgt_i(grant_tgt),
    .word_o     (route_word_o)
  );

  for (genvar l = 0; l < NUM_REQ; l++) begin : g_rsp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rsp_valid_o[l] <= 1'b0;
        rsp_ok_o[l]    <= 1'b0;
        rsp_busy_o[l]  <= 1'b0;
        rsp_err_o[l]   <= 1'b0;
      end else begin
        rsp_valid_o[l] <= code[l] != RSP_NONE;
        rsp_ok_o[l]    <= code[l] == RSP_OK;
        rsp_busy_o[l]  <= code[l] == RSP_BUSY;
        rsp_err_o[l]   <= code[l] == RSP_ERR;
      end
    end

    p_one_result_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_valid_o[l] |-> $onehot({rsp_ok_o[l], rsp_busy_o[l], rsp_err_o[l]}));
    p_no_spurious_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_valid_i[l] |=> !rsp_valid_o[l]);
    p_err_no_change_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i == (NUM_REQ'(1) << l) && req_port_i[l*PORT_W +: PORT_W] == 2'd3)
        |=> ($stable(route_word_o) && $stable(port_owned_o)));
  end
endmodule

// File: tb/usb_route_claim_tb_top.sv
module usb_route_claim_tb_top;
  localparam int NR = 2;
  localparam int NP = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NR-1:0]   v, rl;
  logic [NR*2-1:0] pt, tg;
  logic [NR-1:0]   rsp_v, rsp_ok, rsp_busy, rsp_err;
  logic [31:0]     word;
  logic [NP-1:0]   owned, tgt;

  always #2 clk = ~clk;

  usb_route_claim #(.NUM_REQ(NR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(v), .req_release_i(rl), .req_port_i(pt), .req_target_i(tg),
    .rsp_valid_o(rsp_v), .rsp_ok_o(rsp_ok), .rsp_busy_o(rsp_busy), .rsp_err_o(rsp_err),
    .route_word_o(word), .port_owned_o(owned), .port_target_o(tgt)
  );

  int n_vec = 0, n_bad = 0;
  string cur = "R1";

  // reference state
  int m_own[NP], m_tgt[NP];
  logic [31:0] m_word;
  int exp_rsp[NR]; // 0 none 1 ok 2 busy 3 err

  task automatic chk(input string r, input string what, input longint act, input longint expv);
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, expv);
    end
  endtask

  task automatic compare();
    n_vec++;
    chk(cur, "word", word, m_word);
    for (int p = 0; p < NP; p++) begin
      chk(cur, "owned", owned[p], m_own[p]);
      if (m_own[p] != 0) chk(cur, "target", tgt[p], m_tgt[p]);
    end
    for (int l = 0; l < NR; l++) begin
      chk(cur, "rsp_valid", rsp_v[l], exp_rsp[l] != 0);
      chk(cur, "rsp_ok", rsp_ok[l], exp_rsp[l] == 1);
      chk(cur, "rsp_busy", rsp_busy[l], exp_rsp[l] == 2);
      chk(cur, "rsp_err", rsp_err[l], exp_rsp[l] == 3);
    end
  endtask

  // behavioural model of one request cycle
  task automatic model(input int lv[NR], input int lr[NR], input int lp[NR], input int lt[NR]);
    int start_own[NP];
    int got[NP];
    int relq[$];
    for (int p = 0; p < NP; p++) begin start_own[p] = m_own[p]; got[p] = 0; end
    for (int l = 0; l < NR; l++) begin
      exp_rsp[l] = 0;
      if (lv[l] == 0) continue;
      if (lp[l] > 2) exp_rsp[l] = 3;
      else if (lr[l] != 0) begin exp_rsp[l] = 1; relq.push_back(lp[l]); end
      else if (lt[l] > 1) exp_rsp[l] = 3;
      else if (start_own[lp[l]] != 0 || got[lp[l]] != 0) exp_rsp[l] = 2;
      else begin
        exp_rsp[l] = 1;
        got[lp[l]] = 1;
        m_own[lp[l]] = 1;
        m_tgt[lp[l]] = lt[l];
        if (lp[l] == 0) m_word[5:4] = (lt[l] == 1) ? 2'b11 : 2'b01;
        if (lp[l] == 2) m_word[31]  = (lt[l] == 1);
      end
    end
    foreach (relq[i]) if (got[relq[i]] == 0) m_own[relq[i]] = 0;
  endtask

  // apply at negedge, compare at following negedge
  task automatic step(input int lv[NR], input int lr[NR], input int lp[NR], input int lt[NR]);
    for (int l = 0; l < NR; l++) begin
      v[l] = lv[l][0]; rl[l] = lr[l][0];
      pt[l*2 +: 2] = lp[l][1:0]; tg[l*2 +: 2] = lt[l][1:0];
    end
    model(lv, lr, lp, lt);
    @(negedge clk);
    compare();
  endtask

  task automatic one(input int l, input int r, input int p, input int t);
    int lv[NR], lr[NR], lp[NR], lt[NR];
    for (int k = 0; k < NR; k++) begin lv[k] = 0; lr[k] = 0; lp[k] = 0; lt[k] = 0; end
    lv[l] = 1; lr[l] = r; lp[l] = p; lt[l] = t;
    step(lv, lr, lp, lt);
  endtask

  task automatic two(input int r0, input int p0, input int t0, input int r1, input int p1, input int t1);
    int lv[NR], lr[NR], lp[NR], lt[NR];
    lv[0] = 1; lr[0] = r0; lp[0] = p0; lt[0] = t0;
    lv[1] = 1; lr[1] = r1; lp[1] = p1; lt[1] = t1;
    step(lv, lr, lp, lt);
  endtask

  task automatic idle();
    int lv[NR], lr[NR], lp[NR], lt[NR];
    for (int k = 0; k < NR; k++) begin lv[k] = 0; lr[k] = 0; lp[k] = 0; lt[k] = 0; end
    step(lv, lr, lp, lt);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    v = '0; rl = '0; pt = '0; tg = '0;
    m_word = '0;
    for (int p = 0; p < NP; p++) begin m_own[p] = 0; m_tgt[p] = 0; end
    for (int l = 0; l < NR; l++) exp_rsp[l] = 0;
    repeat (3) @(negedge clk);
    cur = "R1"; compare();
    rst_n = 1'b1;
    @(negedge clk); compare();
    cur = "R1"; idle();

    cur = "R3"; one(0, 0, 0, 0);   // port0 -> 01
    cur = "R2"; idle();
    cur = "R7"; one(1, 1, 0, 0);   // release keeps field
    cur = "R3"; one(1, 0, 0, 1);   // port0 -> 11
    cur = "R4"; one(0, 0, 2, 1);   // bit31 set, port0 field kept
    cur = "R6"; one(0, 0, 0, 0);   // busy, field stays 11
    cur = "R6"; one(1, 0, 2, 0);
    cur = "R8"; one(0, 0, 3, 0);
    cur = "R8"; one(1, 0, 1, 2);
    cur = "R8"; one(0, 1, 3, 0);
    cur = "R5"; one(0, 0, 1, 1);   // port1 owned, word unchanged
    cur = "R7"; one(0, 1, 2, 0);
    cur = "R4"; one(1, 0, 2, 0);   // bit31 cleared
    cur = "R7"; one(1, 1, 0, 0);
    cur = "R9"; two(0, 0, 0, 0, 0, 1); // same idle port: lane0 wins
    cur = "R7"; two(1, 0, 0, 1, 2, 0);
    cur = "R9"; two(0, 2, 1, 0, 0, 1); // different ports both granted
    cur = "R11"; two(0, 0, 0, 1, 0, 0); // owned: busy + release
    cur = "R11"; two(0, 0, 1, 1, 0, 0); // idle: claim wins
    cur = "R10"; idle();
    cur = "R10"; idle();

    cur = "R5";
    for (int i = 0; i < 3000; i++) begin
      int lv[NR], lr[NR], lp[NR], lt[NR];
      for (int l = 0; l < NR; l++) begin
        lv[l] = ($urandom % 4) != 0;
        lr[l] = ($urandom % 3) == 0;
        lp[l] = ($urandom % 8 == 0) ? 3 : int'($urandom % 3);
        lt[l] = ($urandom % 10 == 0) ? 2 : int'($urandom % 2);
      end
      step(lv, lr, lp, lt);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule